// File: doc/BRIEF.md
# Programmable Frame-End Marker Generator

This block sits on a streaming path and adds an end-of-frame flag to the output side. Data, valid and ready pass straight through with no added latency. The block counts the beats that downstream accepts, meaning cycles with valid and ready both high. It raises the end flag on the beat that completes a frame of the configured length.

The frame length sits in a register that can be rewritten at any time through a one-cycle write strobe with a length value. This strobe stands in for a small memory-mapped slave. A write that arrives while a frame is partly sent clears the count and closes that frame early: the next accepted beat carries the end flag. After that beat, the following frame counts the new length from zero. A write that arrives on a frame boundary only changes the length.

Top module: `frame_end_marker`

## Requirements
- R1: `m_data` equals `s_data`, `m_valid` equals `s_valid`, and `s_ready` equals `m_ready` in the same cycle.
- R2: With a fixed length L of 2 or more, `m_last` is high on accepted beat number L, 2L, 3L and so on, and low on every other accepted beat.
- R3: The beat count advances only on an accepted beat (`s_valid` and `m_ready` both high). Idle cycles do not change which later beat carries `m_last`.
- R4: A write (`cfg_wr_en` high at a rising edge) stores `cfg_wr_len`, and the new length applies from the next cycle on.
- R5: While `m_valid` is high and `m_ready` is low, with no write, `m_last` keeps its value from one cycle to the next.
- R6: A stored length of 0 or 1 makes `m_last` high on every accepted beat.
- R7: A write made while a frame is open (at least one beat of it accepted, its last beat not yet accepted, counting any beat accepted in the write cycle) makes the next accepted beat carry `m_last`. The frame after that beat holds the full new length.
- R8: A write made when no frame is open causes no early `m_last`. The next frame holds the full new length.
- R9: On a beat accepted in the same cycle as a write, `m_last` follows the settings that were in force before the write.
- R10: After reset the count is zero and the length is DEF_LEN (16 by default), so the first `m_last` falls on the sixteenth accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Length register write strobe |
| cfg_wr_len | input | LEN_W | Length value to store |
| s_data | input | DATA_W | Upstream data |
| s_valid | input | 1 | Upstream valid |
| s_ready | output | 1 | Ready returned upstream |
| m_data | output | DATA_W | Downstream data |
| m_valid | output | 1 | Downstream valid |
| m_ready | input | 1 | Downstream ready |
| m_last | output | 1 | End-of-frame flag for the current beat |

## Verification
The assertions assume that `cfg_wr_en` is never unknown after reset. They also assume that any upstream source holds its data while stalled. The stall property checks only the flag, so it is not affected when the source breaks that rule. The stimulus draws valid, ready and write strobes from a seeded `$urandom`, with lengths from 0 to 20 so that short and zero lengths occur often. Directed sequences place writes mid-frame, on boundaries and on accepted beats. The ready line is held low over several cycles to exercise stalls.

// File: rtl/fem_pkg.sv
package fem_pkg;
   // How a length write relates to the frame in progress
   typedef enum logic [1:0] {
      WR_NONE     = 2'd0,
      WR_BOUNDARY = 2'd1,
      WR_MIDFRAME = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/fem_len_reg.sv
module fem_len_reg #(
   parameter int LEN_W   = 16,
   parameter int DEF_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LEN_W-1:0] wr_len,
   output logic [LEN_W-1:0] eff_len
);
   localparam logic [LEN_W-1:0] RST_VAL = LEN_W'(DEF_LEN);
   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     len_q <= RST_VAL;
      else if (wr_en) len_q <= wr_len;
   end

   // zero is treated as a one-beat frame
   always_comb eff_len = (len_q == '0) ? ONE : len_q;

   p_len_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> len_q == $past(wr_len));
   p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eff_len != '0);
endmodule

// File: rtl/fem_beat_ctr.sv
module fem_beat_ctr
   import fem_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_acc,
   input  logic             wr_en,
   input  logic [LEN_W-1:0] eff_len,
   output logic             last_flag
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] cnt_q;
   logic             force_q;
   logic             open_after;
   wr_kind_e         wr_kind;

   always_comb begin
      last_flag = force_q || (cnt_q >= (eff_len - ONE));
      // frame still open once this cycle's beat (if any) is counted
      if (beat_acc) open_after = !last_flag;
      else          open_after = (cnt_q != '0) || force_q;
      if (!wr_en)          wr_kind = WR_NONE;
      else if (open_after) wr_kind = WR_MIDFRAME;
      else                 wr_kind = WR_BOUNDARY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         force_q <= 1'b0;
      end else begin
         unique case (wr_kind)
            WR_MIDFRAME: begin
               cnt_q   <= '0;
               force_q <= 1'b1;
            end
            WR_BOUNDARY: begin
               cnt_q   <= '0;
               force_q <= 1'b0;
            end
            default: begin
               if (beat_acc) begin
                  if (last_flag) begin
                     cnt_q   <= '0;
                     force_q <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q + ONE;
                  end
               end
            end
         endcase
      end
   end

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < eff_len);
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_acc && !wr_en) |=> ($stable(cnt_q) && $stable(force_q)));
   p_wrap_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_acc && last_flag && !wr_en) |=> (cnt_q == '0 && !force_q));
   p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt_q == '0);
   p_midframe_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !beat_acc && cnt_q != '0) |=> last_flag);
endmodule

// File: rtl/frame_end_marker.sv
module frame_end_marker #(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 16,
   parameter int DEF_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [LEN_W-1:0]  cfg_wr_len,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              m_last
);
   localparam longint LEN_MAX = (64'd1 << LEN_W) - 1;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len_w
         $error("LEN_W must be within 1..32");
      end
      if (DEF_LEN < 0 || longint'(DEF_LEN) > LEN_MAX) begin : g_bad_def
         $error("DEF_LEN does not fit in LEN_W bits");
      end
   endgenerate

   logic [LEN_W-1:0] eff_len;
   logic             beat_acc;

   assign m_data   = s_data;
   assign m_valid  = s_valid;
   assign s_ready  = m_ready;
   assign beat_acc = s_valid && m_ready;

   fem_len_reg #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_len  (cfg_wr_len),
      .eff_len (eff_len)
   );

   fem_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_acc  (beat_acc),
      .wr_en     (cfg_wr_en),
      .eff_len   (eff_len),
      .last_flag (m_last)
   );

   p_stall_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready && !cfg_wr_en) |=> $stable(m_last));
   p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready == m_ready);
endmodule

// File: tb/frame_end_marker_test.sv
module frame_end_marker_test;
   localparam int DW = 32;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_wr_en;
   logic [LW-1:0] cfg_wr_len;
   logic [DW-1:0] s_data;
   logic          s_valid;
   logic          s_ready;
   logic [DW-1:0] m_data;
   logic          m_valid;
   logic          m_ready;
   logic          m_last;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state, from the requirements
   int mdl_len;
   int mdl_pos;    // beats accepted in the open frame
   bit mdl_early;  // next beat closes the frame early

   always #4 clk = ~clk;

   frame_end_marker #(.DATA_W(DW), .LEN_W(LW), .DEF_LEN(16)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_len(cfg_wr_len),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
      .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last));

   function automatic int frame_size(int l);
      return (l < 2) ? 1 : l;
   endfunction

   function automatic bit want_last();
      return mdl_early || (mdl_pos + 1 >= frame_size(mdl_len));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check before posedge, update model at posedge
   task automatic step(bit v, bit r, bit w, int wl, string req);
      bit acc, exp_l, open;
      @(negedge clk);
      s_valid = v; m_ready = r; cfg_wr_en = w; cfg_wr_len = LW'(wl);
      s_data = $urandom;
      #2;
      check(m_data == s_data && m_valid == v && s_ready == r, "R1",
            int'(m_valid), int'(v));
      exp_l = want_last();
      acc = v && r;
      if (acc || (v && !r))
         check(m_last == exp_l, req, int'(m_last), int'(exp_l));
      @(posedge clk);
      if (w) begin
         open = acc ? !exp_l : (mdl_pos != 0 || mdl_early);
         mdl_pos = 0; mdl_early = open; mdl_len = wl;
      end else if (acc) begin
         if (exp_l) begin mdl_pos = 0; mdl_early = 0; end
         else mdl_pos++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; cfg_wr_en = 0; cfg_wr_len = '0; s_valid = 0; m_ready = 0; s_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      mdl_len = 16; mdl_pos = 0; mdl_early = 0;
      // R10: default length 16, first last on beat 16
      for (int i = 0; i < 16; i++) step(1, 1, 0, 0, "R10");
      // R2: length 5, with idle gaps (R3)
      step(0, 0, 1, 5, "R4");
      for (int i = 0; i < 15; i++) begin
         step(1, 1, 0, 0, "R2");
         step(i % 3 == 0, 0, 0, 0, "R3");
      end
      // R5: stall mid-frame
      step(1, 1, 0, 0, "R2");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R5");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R5");
      // R6: length 0 and length 1
      step(0, 0, 1, 0, "R6");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R6");
      step(0, 0, 1, 1, "R6");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R6");
      // R8: write at boundary, then full frame of 4
      step(0, 0, 1, 4, "R8");
      for (int i = 0; i < 8; i++) step(1, 1, 0, 0, "R8");
      // R7: mid-frame write, early last, then full 6
      step(1, 1, 0, 0, "R7");
      step(1, 1, 0, 0, "R7");
      step(0, 0, 1, 6, "R7");
      step(1, 1, 0, 0, "R7");
      for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R7");
      // R9: write on accepted beat, old settings rule that beat
      step(1, 1, 0, 0, "R9");
      step(1, 1, 1, 3, "R9");
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R9");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit w = ($urandom % 20) == 0;
         step(($urandom % 4) != 0, ($urandom % 3) != 0, w, $urandom % 21, "R2");
      end
      finish_run();
   end
endmodule